// File: doc/BRIEF.md
# Security Register Read Sequencer

This block sits on the host side of a flash device and fetches the device's one-time security register. A single start pulse runs a whole read. Chip select goes low and the read opcode goes out, followed by a run of don't-care bytes. The block then collects the number of register bytes that was asked for and raises chip select again. Each collected byte appears on an 8-bit output together with a one-cycle valid strobe. There is no backpressure, so the consumer must take every byte.

Two bus modes are supported, and a mode input selects one at the start pulse. In serial mode there is one bit per bus clock, driven on the falling edge and sampled on the rising edge, MSB first, with the bus clock idling low. In byte-wide mode a whole byte moves on each bus clock. The two modes need different numbers of don't-care bytes. The device returns undefined data once the end of the register is reached, so the block never captures anything past the register length. Each bus clock phase lasts one system clock, which makes one bus clock two system clocks long.

Top module: `secreg_fetch`

## Requirements
- R1: After a start pulse in idle, `cs_n` goes low, and the first byte sent is the opcode 0x77, MSB first in serial mode or as one byte on `bus_out` in byte-wide mode.
- R2: In serial mode (`par_mode`=0), three don't-care bytes follow the opcode, and each byte takes 16 system clocks. `cs_n` therefore stays low for exactly (4+N)*16 cycles, where N is the number of data bytes read.
- R3: In byte-wide mode (`par_mode`=1), seven don't-care bytes follow the opcode, and each byte takes 2 system clocks, so `cs_n` stays low for (8+N)*2 cycles. `bus_oe` is high while the opcode and don't-care bytes are driven, and it is low before the first data byte is sampled.
- R4: Captured bytes come out on `rd_data` in register order, starting at byte 0. Each byte comes with exactly one cycle of `rd_valid`.
- R5: A `req_len` larger than REG_BYTES (default 128) is clamped to REG_BYTES. No more than REG_BYTES bytes are ever presented.
- R6: A `req_len` of 0 still sends the opcode and the don't-care bytes, but it presents no data bytes.
- R7: `busy` is high from the cycle after the start pulse until the cycle in which `cs_n` returns high. In that cycle `done` is high for exactly one cycle.
- R8: A start pulse, a `par_mode` change or a `req_len` change while a read is in progress has no effect on that read and does not start a new one.
- R9: While reset is held (active-high, synchronous): `cs_n`=1, `sck`=0, `busy`=0, `done`=0, `rd_valid`=0, `bus_oe`=0.
- R10: `sck` is low whenever `cs_n` is high, and in serial mode `mosi` never changes on a rising `sck` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read (accepted only when idle) |
| par_mode | input | 1 | 0 = serial, 1 = byte-wide bus |
| req_len | input | LEN_W | Number of register bytes requested |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle end-of-read pulse |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Bus clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| bus_out | output | 8 | Byte-wide data to the device |
| bus_oe | output | 1 | Byte-wide bus drive enable |
| bus_in | input | 8 | Byte-wide data from the device |
| rd_data | output | 8 | Captured register byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |

## Verification
The assertions assume that `start` is raised only as a single-cycle pulse. They also assume that the device model changes `miso` or `bus_in` only on falling `sck` edges. The bench meets both assumptions: start is driven for one cycle from a task, and the device model updates its outputs only on negative `sck` edges. The model keeps count of the bits or bytes it has received and does not rely on the block's state. It also drives a fixed non-register pattern past the register end, so any byte captured there would show up as an extra or mismatching byte. The mode and length inputs are deliberately changed mid-read in one run, to test that they are latched at start.

// File: rtl/secreg_pkg.sv
package secreg_pkg;

    localparam logic [7:0]  OPC_SECREG_READ = 8'h77;
    localparam int unsigned DUMMY_SERIAL    = 3;
    localparam int unsigned DUMMY_WIDE      = 7;
    localparam int unsigned BITS_PER_BYTE   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_DUMMY,
        ST_DATA,
        ST_DONE
    } seq_state_t;

    function automatic int unsigned dummy_bytes(input logic wide);
        return wide ? DUMMY_WIDE : DUMMY_SERIAL;
    endfunction

endpackage

// File: rtl/secreg_beat.sv
module secreg_beat
    import secreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic wide,
    output logic sck,
    output logic sample,
    output logic shift,
    output logic beat_end
);
    localparam int BW = $clog2(BITS_PER_BYTE);
    localparam logic [BW-1:0] LAST_BIT = BW'(BITS_PER_BYTE - 1);

    logic          phase_q;
    logic [BW-1:0] bit_q;
    logic          last_bit;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= 1'b0;
            bit_q   <= '0;
        end else begin
            phase_q <= !phase_q;
            if (phase_q)
                bit_q <= (wide || last_bit) ? '0 : bit_q + 1'b1;
        end
    end

    assign last_bit = (bit_q == LAST_BIT);
    assign sck      = phase_q;
    assign sample   = run && !phase_q;
    assign beat_end = run && phase_q && (wide || last_bit);
    assign shift    = run && phase_q && !wide && !last_bit;

endmodule

// File: rtl/secreg_shift.sv
module secreg_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       shift,
    input  logic       sample,
    input  logic       wide,
    input  logic       miso,
    input  logic [7:0] bus_in,
    output logic [7:0] tx,
    output logic [7:0] rx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx <= '0;
            rx <= '0;
        end else begin
            if (load)
                tx <= load_val;
            else if (shift)
                tx <= {tx[6:0], 1'b0};
            if (sample)
                rx <= wide ? bus_in : {rx[6:0], miso};
        end
    end
endmodule

// File: rtl/secreg_fetch.sv
module secreg_fetch
    import secreg_pkg::*;
#(
    parameter int REG_BYTES = 128,
    parameter int LEN_W     = $clog2(REG_BYTES) + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             par_mode,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic             done,
    output logic             cs_n,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic [7:0]       bus_out,
    output logic             bus_oe,
    input  logic [7:0]       bus_in,
    output logic [7:0]       rd_data,
    output logic             rd_valid
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(REG_BYTES);

    seq_state_t       state;
    logic             cs_n_q, wide_q, rd_valid_q;
    logic [LEN_W-1:0] len_q, cnt_q, len_clamped;
    logic [7:0]       rd_data_q, tx, rx;
    logic             run, sample, shift, beat_end, load;
    logic [7:0]       load_val;
    logic             last_dummy;

    assign run         = (state == ST_OPCODE) || (state == ST_DUMMY) || (state == ST_DATA);
    assign len_clamped = (req_len > MAX_LEN) ? MAX_LEN : req_len;
    assign last_dummy  = (cnt_q == LEN_W'(dummy_bytes(wide_q) - 1));
    assign load        = ((state == ST_IDLE) && start) ||
                         (beat_end && ((state == ST_OPCODE) || (state == ST_DUMMY)));
    assign load_val    = (state == ST_IDLE) ? OPC_SECREG_READ : 8'h00;

    secreg_beat u_beat (
        .clk(clk), .rst(rst), .run(run), .wide(wide_q),
        .sck(sck), .sample(sample), .shift(shift), .beat_end(beat_end)
    );

    secreg_shift u_shift (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .shift(shift), .sample(sample), .wide(wide_q), .miso(miso),
        .bus_in(bus_in), .tx(tx), .rx(rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cs_n_q     <= 1'b1;
            wide_q     <= 1'b0;
            len_q      <= '0;
            cnt_q      <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_OPCODE;
                    cs_n_q <= 1'b0;
                    wide_q <= par_mode;
                    len_q  <= len_clamped;
                    cnt_q  <= '0;
                end
                ST_OPCODE: if (beat_end) begin
                    state <= ST_DUMMY;
                    cnt_q <= '0;
                end
                ST_DUMMY: if (beat_end) begin
                    if (last_dummy) begin
                        cnt_q <= '0;
                        if (len_q == '0) begin
                            state  <= ST_DONE;
                            cs_n_q <= 1'b1;
                        end else begin
                            state <= ST_DATA;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: if (beat_end) begin
                    rd_valid_q <= 1'b1;
                    rd_data_q  <= rx;
                    if (cnt_q == len_q - 1'b1) begin
                        state  <= ST_DONE;
                        cs_n_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = run;
    assign done     = (state == ST_DONE);
    assign cs_n     = cs_n_q;
    assign mosi     = (!wide_q && run) ? tx[7] : 1'b0;
    assign bus_oe   = wide_q && ((state == ST_OPCODE) || (state == ST_DUMMY));
    assign bus_out  = bus_oe ? tx : 8'h00;
    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    // R7: chip select held low for the whole busy window
    a_r7_cs_busy: assert property (@(posedge clk) disable iff (rst) busy |-> !cs_n);
    // R7: done is a single-cycle pulse and busy has already dropped
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done && !busy);
    // R10: bus clock idles low while deselected
    a_r10_sck_idle: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sck);
    // R10: serial data never moves on a rising bus clock
    a_r10_mosi_stable: assert property (@(posedge clk) disable iff (rst)
        (!wide_q && $rose(sck)) |-> $stable(mosi));
    // R3: bus released whenever a byte is being presented
    a_r3_oe_released: assert property (@(posedge clk) disable iff (rst) rd_valid |-> !bus_oe);
    // R5: latched length never exceeds the register size
    a_r5_len_bound: assert property (@(posedge clk) disable iff (rst) busy |-> (len_q <= MAX_LEN));
    // R8: mode and length stay latched for the whole read
    a_r8_latched: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(wide_q) && $stable(len_q)));

endmodule

// File: tb/secreg_fetch_bench.sv
`timescale 1ns/1ps
module secreg_fetch_bench;
    localparam int REG_BYTES = 128;
    localparam int LEN_W     = $clog2(REG_BYTES) + 2;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, par_mode = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic miso = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic busy, done, cs_n, sck, mosi, bus_oe, rd_valid;
    logic [7:0] bus_out, rd_data;

    int errors = 0, checks = 0;
    int lowcnt = 0, donecnt = 0, vldcnt = 0, nbits = 0;
    logic [7:0] op_rx = 8'h00;
    logic [7:0] exp_q[$];
    logic cur_par = 1'b0, contention = 1'b0;

    always #2 clk = ~clk;

    secreg_fetch #(.REG_BYTES(REG_BYTES), .LEN_W(LEN_W)) u_secreg_fetch (
        .clk(clk), .rst(rst), .start(start), .par_mode(par_mode), .req_len(req_len),
        .busy(busy), .done(done), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [7:0] reg_val(input int i);
        return 8'((i * 29 + 60) ^ (i >> 3));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // device model: receive on rising sck
    always @(posedge sck or posedge cs_n) begin
        if (cs_n === 1'b1) nbits = 0;
        else begin
            if (cur_par) begin
                if (nbits == 0) op_rx = bus_out;
                if (nbits >= 8 && bus_oe) contention = 1'b1;
            end else if (nbits < 8) begin
                op_rx[7 - nbits] = mosi;
            end
            nbits++;
        end
    end

    // device model: drive on falling sck
    always @(negedge sck) begin : drv
        int idx;
        logic [7:0] b;
        if (cs_n === 1'b0) begin
            if (cur_par) begin
                if (nbits >= 8)
                    bus_in = (nbits - 8 < REG_BYTES) ? reg_val(nbits - 8) : 8'hEE;
            end else if (nbits >= 32) begin
                idx  = nbits - 32;
                b    = (idx / 8 < REG_BYTES) ? reg_val(idx / 8) : 8'hEE;
                miso = b[7 - (idx % 8)];
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin : mon
        logic [7:0] e;
        if (!rst) begin
            if (!cs_n) lowcnt++;
            if (done) donecnt++;
            if (rd_valid) begin
                vldcnt++;
                if (exp_q.size() == 0)
                    check(1'b0, "R5", "byte beyond request", rd_data, -1);
                else begin
                    e = exp_q.pop_front();
                    check(rd_data == e, "R4", "data byte", rd_data, e);
                end
            end
        end
    end

    task automatic run_read(input bit par, input int len, input bit disturb);
        int n   = (len > REG_BYTES) ? REG_BYTES : len;
        int d   = par ? 7 : 3;
        int per = par ? 2 : 16;
        int waitc = 0;
        string rq;
        exp_q.delete();
        for (int i = 0; i < n; i++) exp_q.push_back(reg_val(i));
        @(negedge clk);
        lowcnt = 0; donecnt = 0; vldcnt = 0; contention = 1'b0; op_rx = 8'h00;
        cur_par = par; par_mode = par; req_len = LEN_W'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7", "busy after start", busy, 1);
        check(cs_n == 1'b0, "R1", "cs_n low after start", cs_n, 0);
        if (disturb) begin
            repeat (10) @(negedge clk);
            par_mode = !par; req_len = LEN_W'(3); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && waitc < 20000) begin
            @(negedge clk);
            waitc++;
        end
        check(done == 1'b1, "R7", "done reached", done, 1);
        check(cs_n == 1'b1 && busy == 1'b0, "R7", "cs_n high and busy low with done",
              {cs_n, busy}, 2);
        @(negedge clk);
        check(done == 1'b0, "R7", "done lasts one cycle", done, 0);
        repeat (4) @(negedge clk);
        check(op_rx == 8'h77, "R1", "opcode received", op_rx, 8'h77);
        rq = disturb ? "R8" : (par ? "R3" : "R2");
        check(lowcnt == (1 + d + n) * per, rq, "cs_n low cycles", lowcnt, (1 + d + n) * per);
        rq = (len > REG_BYTES) ? "R5" : ((len == 0) ? "R6" : "R4");
        check(vldcnt == n, rq, "valid strobes", vldcnt, n);
        check(exp_q.size() == 0, rq, "bytes missing", exp_q.size(), 0);
        check(donecnt == 1, "R7", "done pulse count", donecnt, 1);
        check(cs_n == 1'b1 && sck == 1'b0, "R10", "idle cs_n/sck", {cs_n, sck}, 2);
        if (par) check(!contention, "R3", "bus_oe low in data", contention, 0);
        if (disturb) check(busy == 1'b0, "R8", "no second read started", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1, "R9", "reset cs_n", cs_n, 1);
        check(sck == 1'b0, "R9", "reset sck", sck, 0);
        check(busy == 1'b0 && done == 1'b0, "R9", "reset busy/done", {busy, done}, 0);
        check(rd_valid == 1'b0 && bus_oe == 1'b0, "R9", "reset valid/oe", {rd_valid, bus_oe}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        run_read(1'b0, 4, 1'b0);
        run_read(1'b1, 5, 1'b0);
        run_read(1'b0, 0, 1'b0);
        run_read(1'b1, 0, 1'b0);
        run_read(1'b1, 200, 1'b0);
        run_read(1'b0, 130, 1'b0);
        run_read(1'b1, 128, 1'b0);
        run_read(1'b0, 3, 1'b1);
        run_read(1'b1, 6, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule